// File: doc/BRIEF.md
# Halfword PIO Data FIFO

This block buffers data between a 16-bit host data register and the byte-wide SD data path during programmed-I/O transfers. It holds one byte-organised store with two directions of use. In receive mode the card side pushes single bytes and the host removes 16-bit halfwords. In transmit mode the host adds halfwords and the card side drains single bytes. Within each halfword the byte order is little-endian: the byte that comes earlier on the card stream sits in bits 7:0 and the later byte sits in bits 15:8.

The block reports readiness at two sizes, a 4-byte unit and a 32-byte burst, so the host can move either two halfwords or sixteen halfwords per service. It also drives the empty, full and activity bits of the host status word. The card byte ports use valid/ready. A card byte is taken on a cycle where both `cin_valid` and `cin_ready` are high. A card byte leaves on a cycle where both `cout_valid` and `cout_ready` are high. `cout_data` holds steady while `cout_valid` is high and no byte leaves. The host ports are posted single-cycle strobes, not held handshakes. A host write offered while `hwr_ready` is low is discarded. A host read strobed while `hrd_ready` is low returns zero and removes nothing. Software uses synchronous `soft_rst` to clear the FIFO between transfers.

Top module: `pio_half_fifo`

## Requirements
- R1: In receive mode, `hrd_data` carries the earlier of the two oldest card bytes in bits 7:0 and the later one in bits 15:8. In transmit mode, bits 7:0 of a host halfword leave on `cout_data` before bits 15:8.
- R2: `rd_rdy` is high exactly when `rx_mode` is 1 and at least 4 bytes are stored.
- R3: `rd_burst_rdy` is high exactly when `rx_mode` is 1 and at least 32 bytes are stored.
- R4: `wr_rdy` is high exactly when `rx_mode` is 0 and at least 4 bytes are free. `wr_burst_rdy` is high exactly when `rx_mode` is 0 and at least 32 bytes are free.
- R5: `st_empty` is high exactly when 0 bytes are stored. `st_full` is high exactly when DEPTH bytes (64 by default) are stored.
- R6: `st_rx_active` is high when `rx_mode` is 1 and the store is not empty. `st_tx_active` is high when `rx_mode` is 0 and the store is not empty.
- R7: In receive mode, a host read strobe with fewer than 2 bytes stored sees `hrd_data` = 0 and removes no data.
- R8: In transmit mode, a host write with fewer than 2 bytes free is dropped. It stores nothing, and later data is not disturbed.
- R9: `cin_ready` equals `rx_mode` AND NOT full. `cout_valid` equals NOT `rx_mode` AND NOT empty. Traffic offered on the side that does not match the mode has no effect.
- R10: A `soft_rst` cycle empties the FIFO. After it, `st_empty` = 1 and all ready flags show the empty state.
- R11: Bytes leave in the order they entered, and a full store holds exactly DEPTH bytes.
- R12: After `rst_n`, the FIFO is empty, `hrd_data` = 0, and the receive flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of pointers and count |
| rx_mode | input | 1 | 1 = card to host, 0 = host to card |
| cin_valid | input | 1 | Card byte offered |
| cin_ready | output | 1 | Card byte can be taken |
| cin_data | input | 8 | Card byte |
| cout_valid | output | 1 | Byte available to the card side |
| cout_ready | input | 1 | Card side takes the byte |
| cout_data | output | 8 | Oldest stored byte |
| hrd_req | input | 1 | Host reads one halfword |
| hrd_ready | output | 1 | A halfword is available to the host |
| hrd_data | output | 16 | Halfword seen by the host, 0 when none |
| hwr_valid | input | 1 | Host writes one halfword |
| hwr_ready | output | 1 | Room for one halfword |
| hwr_data | input | 16 | Halfword from the host |
| rd_rdy | output | 1 | Receive: 4 bytes or more available |
| rd_burst_rdy | output | 1 | Receive: 32 bytes or more available |
| wr_rdy | output | 1 | Transmit: 4 bytes or more free |
| wr_burst_rdy | output | 1 | Transmit: 32 bytes or more free |
| st_empty | output | 1 | Store empty |
| st_full | output | 1 | Store full |
| st_rx_active | output | 1 | Receive data pending |
| st_tx_active | output | 1 | Transmit data pending |

## Verification
The bench goes after the threshold edges: 3 bytes against 4 bytes for the unit flag, 31 against 32 for the burst flag, and 30 against 32 free and 4 against 2 free in transmit mode. An off-by-one compare would show a flag one access early or late. It drives a host read on an empty store and a host write on a full one. A design that moved a pointer there would return a stale or shifted halfword later, or push an extra halfword to the card side, and the scoreboard would catch either. The bench also offers traffic on the inactive side, fills the store to exactly 64 bytes, and checks the halfword byte order against the queue. A swapped byte lane or a wrong wrap point would show as a scoreboard mismatch.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  typedef struct packed {
    logic rd_unit;
    logic rd_burst;
    logic wr_unit;
    logic wr_burst;
  } lvl_flags_t;

  typedef struct packed {
    logic empty;
    logic full;
    logic rx_act;
    logic tx_act;
  } stat_bits_t;
endpackage

// File: rtl/pio_fifo_store.sv
module pio_fifo_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_byte_en,
  input  logic          wr_half_en,
  input  logic [AW-1:0] wr_ptr,
  input  logic [7:0]    wr_byte,
  input  logic [15:0]   wr_half,
  input  logic [AW-1:0] rd_ptr,
  output logic [7:0]    rd_byte,
  output logic [15:0]   rd_half
);
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] wr_nxt, rd_nxt;

  assign wr_nxt = wr_ptr + AW'(1);
  assign rd_nxt = rd_ptr + AW'(1);

  always_ff @(posedge clk) begin
    if (wr_byte_en) begin
      mem[wr_ptr] <= wr_byte;
    end else if (wr_half_en) begin
      mem[wr_ptr] <= wr_half[7:0];
      mem[wr_nxt] <= wr_half[15:8];
    end
  end

  assign rd_byte = mem[rd_ptr];
  assign rd_half = {mem[rd_nxt], mem[rd_ptr]};
endmodule

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [1:0]    push_n,
  input  logic [1:0]    pop_n,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (soft_rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  // R11: occupancy never exceeds the store
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R10: soft reset leaves nothing stored
  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (count == '0) && (wr_ptr == rd_ptr));
endmodule

// File: rtl/pio_fifo_flags.sv
module pio_fifo_flags
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int CW          = $clog2(DEPTH + 1),
  parameter int UNIT_BYTES  = 4,
  parameter int BURST_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_mode,
  input  logic [CW-1:0] count,
  output lvl_flags_t    lvl,
  output stat_bits_t    stat
);
  logic [CW-1:0] free_b;
  logic [1:0]    have_lvl, room_lvl;

  assign free_b = CW'(DEPTH) - count;

  // index 0: unit granularity, index 1: burst granularity
  for (genvar g = 0; g < 2; g++) begin : g_thr
    localparam int THR = (g == 0) ? UNIT_BYTES : BURST_BYTES;
    assign have_lvl[g] = rx_mode  && (count  >= CW'(THR));
    assign room_lvl[g] = !rx_mode && (free_b >= CW'(THR));
  end

  assign lvl.rd_unit  = have_lvl[0];
  assign lvl.rd_burst = have_lvl[1];
  assign lvl.wr_unit  = room_lvl[0];
  assign lvl.wr_burst = room_lvl[1];

  assign stat.empty  = (count == '0);
  assign stat.full   = (count == CW'(DEPTH));
  assign stat.rx_act = rx_mode  && !stat.empty;
  assign stat.tx_act = !rx_mode && !stat.empty;

  // R3: a burst of data implies a unit of data
  assert_burst_has_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl.rd_burst |-> lvl.rd_unit);

  // R5: the store is never both full and empty
  assert_full_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat.full |-> !stat.empty);
endmodule

// File: rtl/pio_half_fifo.sv
module pio_half_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int UNIT_BYTES  = 4,
  parameter int BURST_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        rx_mode,
  input  logic        cin_valid,
  output logic        cin_ready,
  input  logic [7:0]  cin_data,
  output logic        cout_valid,
  input  logic        cout_ready,
  output logic [7:0]  cout_data,
  input  logic        hrd_req,
  output logic        hrd_ready,
  output logic [15:0] hrd_data,
  input  logic        hwr_valid,
  output logic        hwr_ready,
  input  logic [15:0] hwr_data,
  output logic        rd_rdy,
  output logic        rd_burst_rdy,
  output logic        wr_rdy,
  output logic        wr_burst_rdy,
  output logic        st_empty,
  output logic        st_full,
  output logic        st_rx_active,
  output logic        st_tx_active
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, free_b;
  logic [1:0]    push_n, pop_n;
  logic          cin_fire, cout_fire, hrd_fire, hwr_fire;
  logic [7:0]    rd_byte;
  logic [15:0]   rd_half;
  lvl_flags_t    lvl;
  stat_bits_t    stat;

  assign free_b     = CW'(DEPTH) - count;
  assign cin_ready  = rx_mode && !stat.full;
  assign cout_valid = !rx_mode && !stat.empty;
  assign hrd_ready  = rx_mode && (count >= CW'(2));
  assign hwr_ready  = !rx_mode && (free_b >= CW'(2));

  assign cin_fire  = cin_valid && cin_ready;
  assign cout_fire = cout_valid && cout_ready;
  assign hrd_fire  = hrd_req && hrd_ready;
  assign hwr_fire  = hwr_valid && hwr_ready;

  assign push_n = cin_fire ? 2'd1 : (hwr_fire ? 2'd2 : 2'd0);
  assign pop_n  = hrd_fire ? 2'd2 : (cout_fire ? 2'd1 : 2'd0);

  pio_fifo_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .wr_byte_en(cin_fire),
    .wr_half_en(hwr_fire),
    .wr_ptr    (wr_ptr),
    .wr_byte   (cin_data),
    .wr_half   (hwr_data),
    .rd_ptr    (rd_ptr),
    .rd_byte   (rd_byte),
    .rd_half   (rd_half)
  );

  pio_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .push_n  (push_n),
    .pop_n   (pop_n),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .count   (count)
  );

  pio_fifo_flags #(.DEPTH(DEPTH), .CW(CW), .UNIT_BYTES(UNIT_BYTES),
                   .BURST_BYTES(BURST_BYTES)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_mode(rx_mode),
    .count  (count),
    .lvl    (lvl),
    .stat   (stat)
  );

  assign hrd_data     = hrd_ready ? rd_half : 16'h0000;
  assign cout_data    = rd_byte;
  assign rd_rdy       = lvl.rd_unit;
  assign rd_burst_rdy = lvl.rd_burst;
  assign wr_rdy       = lvl.wr_unit;
  assign wr_burst_rdy = lvl.wr_burst;
  assign st_empty     = stat.empty;
  assign st_full      = stat.full;
  assign st_rx_active = stat.rx_act;
  assign st_tx_active = stat.tx_act;

  // R7: a host read with too little data leaves the occupancy alone
  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && hrd_req && !hrd_ready && !cin_fire && !soft_rst)
      |=> count == $past(count));

  // R8: a host write into a full store adds nothing
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && hwr_valid && !hwr_ready && !soft_rst)
      |=> count <= $past(count));
endmodule

// File: tb/tb_pio_half_fifo.sv
`timescale 1ns/1ps
module tb_pio_half_fifo;
  logic clk = 0;
  logic rst_n = 0, soft_rst = 0, rx_mode = 1;
  logic cin_valid = 0, cout_ready = 0, hrd_req = 0, hwr_valid = 0;
  logic [7:0] cin_data = 0;
  logic [15:0] hwr_data = 0;
  logic cin_ready, cout_valid, hrd_ready, hwr_ready;
  logic [7:0] cout_data;
  logic [15:0] hrd_data;
  logic rd_rdy, rd_burst_rdy, wr_rdy, wr_burst_rdy;
  logic st_empty, st_full, st_rx_active, st_tx_active;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  pio_half_fifo dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic card_push(input logic [7:0] b);
    cin_valid = 1; cin_data = b;
    if (cin_ready) exp_q.push_back(b);
    step();
    cin_valid = 0;
  endtask

  task automatic host_read(input string tag);
    logic [15:0] e;
    hrd_req = 1;
    if (exp_q.size() >= 2) begin
      e = {exp_q[1], exp_q[0]};
      void'(exp_q.pop_front()); void'(exp_q.pop_front());
    end else e = 16'h0;
    check(tag, hrd_data, e);
    step();
    hrd_req = 0;
  endtask

  task automatic host_write(input logic [15:0] h);
    hwr_valid = 1; hwr_data = h;
    if (hwr_ready) begin exp_q.push_back(h[7:0]); exp_q.push_back(h[15:8]); end
    step();
    hwr_valid = 0;
  endtask

  // scoreboard monitor for bytes leaving to the card side (R1, R11)
  always @(negedge clk) begin
    if (cout_valid && cout_ready) begin
      if (exp_q.size() == 0) check("R11 unexpected card byte", cout_data, 32'hFFFF);
      else check("R1 R11 card byte order", cout_data, exp_q.pop_front());
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R12 reset state
    check("R12 empty", st_empty, 1); check("R12 full", st_full, 0);
    check("R12 hrd_data", hrd_data, 0); check("R12 rd_rdy", rd_rdy, 0);
    rst_n = 1; step();
    // R2 unit threshold, R1 order, R6
    card_push(8'h11); card_push(8'h22); card_push(8'h33);
    check("R2 3 bytes", rd_rdy, 0);
    check("R6 rx_active", st_rx_active, 1); check("R6 tx_active", st_tx_active, 0);
    check("R9 cout_valid in rx", cout_valid, 0);
    card_push(8'h44);
    check("R2 4 bytes", rd_rdy, 1);
    check("R1 low byte first", hrd_data, 16'h2211);
    host_read("R1 read 0"); host_read("R1 read 1");
    check("R5 empty after drain", st_empty, 1);
    // R7 empty read then order unaffected
    host_read("R7 empty read");
    card_push(8'h55);
    host_read("R7 one-byte read");
    card_push(8'h66);
    host_read("R7 order kept");
    // R3 burst threshold, R5 full, R9, R11
    for (int i = 0; i < 31; i++) card_push(8'(i + 8'h80));
    check("R3 31 bytes", rd_burst_rdy, 0);
    card_push(8'h9F);
    check("R3 32 bytes", rd_burst_rdy, 1);
    for (int i = 0; i < 32; i++) card_push(8'(i + 8'hC0));
    check("R5 full", st_full, 1); check("R9 cin_ready full", cin_ready, 0);
    card_push(8'hEE);
    check("R11 capacity", exp_q.size(), 64);
    for (int i = 0; i < 32; i++) host_read("R11 rx order");
    check("R5 empty", st_empty, 1);
    // R10 soft reset
    card_push(8'h01); card_push(8'h02); card_push(8'h03); card_push(8'h04);
    soft_rst = 1; step(); soft_rst = 0; exp_q.delete();
    check("R10 empty", st_empty, 1); check("R10 rd_rdy", rd_rdy, 0);
    // transmit mode
    rx_mode = 0; #1;
    check("R4 wr_rdy empty", wr_rdy, 1); check("R4 wr_burst empty", wr_burst_rdy, 1);
    check("R9 cin_ready tx", cin_ready, 0);
    card_push(8'h77);
    check("R9 ignored card push", st_empty, 1);
    for (int i = 0; i < 32; i++) begin
      host_write(16'hA000 + 16'(i * 16'h0102));
      if (i == 15) check("R4 burst at 32 free", wr_burst_rdy, 1);
      if (i == 16) check("R4 burst at 30 free", wr_burst_rdy, 0);
      if (i == 29) check("R4 unit at 4 free", wr_rdy, 1);
      if (i == 30) check("R4 unit at 2 free", wr_rdy, 0);
    end
    check("R5 tx full", st_full, 1); check("R6 tx_active", st_tx_active, 1);
    host_write(16'hDEAD);
    check("R8 dropped", exp_q.size(), 64);
    hrd_req = 1; step(); hrd_req = 0;
    check("R9 host read ignored in tx", st_full, 1);
    cout_ready = 1;
    while (!st_empty) step();
    cout_ready = 0;
    check("R8 R11 all drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule